// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Transceiver

This block moves bytes over a bit-serial synchronous link. Each direction runs on its own bit clock, supplied from outside. The parallel side has a byte-wide valid/ready handshake for each direction. A transmit holding register sits in front of a shift register, and the line sends the most significant bit first. A receive shifter finds byte boundaries, delivers bytes, and closes a frame after a programmed number of bytes. No end-of-text character is needed for that.

Two independent configuration bits decide how synchronization works, which gives four modes. `cfg_no_tx_sync` decides whether the transmitter fills empty byte slots with a sync character. `cfg_ext_sync` decides how the receiver finds byte alignment:
- with `cfg_ext_sync` clear, it hunts for a 16-bit pattern on the line;
- with `cfg_ext_sync` set, it aligns to the external `cd` input.

One combination sends raw data but still hunts for a pattern before it receives. A separate bit, `cfg_hw_ctl`, decides whether the `cts` and `cd` inputs gate transmission and reception. All state is held in plain flip-flops, so either bit clock may stop at any level for any length of time.

Configuration inputs are assumed stable while the link runs. `rst_n` is synchronous and must be held low across at least one edge of each bit clock.

Top module: `sx_transceiver`

## Requirements
- R1: While `rst_n` is low, every bit-clock edge puts the block in its idle state: `tx_line`=1, `tx_ready`=1, `tx_underrun`=0, `rx_valid`=0, `rx_synced`=0, `rx_frame_done`=0, `rx_overrun`=0.
- R2: One byte is taken when `tx_valid` and `tx_ready` are both high at a `tx_clk` edge. `tx_ready` then stays low until that byte moves into the shifter at the next 8-bit slot boundary. Bytes go out one bit per `tx_clk`, most significant bit first.
- R3: A slot that starts with no byte held and with transmission allowed is filled as follows:
  - with `cfg_no_tx_sync`=0, it carries `cfg_sync_char`;
  - with `cfg_no_tx_sync`=1, it carries eight ones, and `tx_underrun` pulses for one cycle if the previous slot carried data.
- R4: With `cfg_ext_sync`=0, the receiver compares the last 16 received bits with `cfg_sync_pat` on every `rx_clk` edge. Bit 15 of the pattern is the earliest bit. The bit after a match is the most significant bit of the first byte. No byte is delivered before a match.
- R5: With `cfg_ext_sync`=1, the pattern is ignored. Alignment is taken at the `rx_clk` edge where `cd` is sampled high while hunting, and the next bit is the most significant bit of the first byte.
- R6: With `cfg_no_tx_sync`=0, a completed byte equal to `cfg_sync_char` is discarded and does not count toward the frame. With `cfg_no_tx_sync`=1, such a byte is delivered.
- R7: When a frame reaches `cfg_max_len` delivered bytes:
  - `rx_frame_done` pulses in the cycle the last byte becomes valid;
  - the receiver then returns to hunting.

  A `cfg_max_len` of 0 never ends a frame.
- R8: With `cfg_hw_ctl`=1, a slot that starts while `cts` is low sends eight ones. It consumes no held byte, sends no sync character and raises no underrun.
- R9: With `cfg_hw_ctl`=1, `cd` low while synchronized drops alignment at that edge. It discards the partial byte and restarts the frame byte count.
- R10: With `cfg_hw_ctl`=0, `cts` never holds back transmission, and `cd` never stops reception or pattern acquisition.
- R11: A byte that completes while the previous byte is still unaccepted is dropped, and `rx_overrun` pulses for one cycle. `rx_data` and `rx_valid` keep the earlier byte.
- R12: Stopping both bit clocks for any time in the middle of a frame loses no state, and the frame resumes intact when the clocks restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit bit clock |
| rx_clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_no_tx_sync | input | 1 | 1: no sync characters inserted on transmit |
| cfg_ext_sync | input | 1 | 1: receive alignment from `cd`; 0: from pattern match |
| cfg_hw_ctl | input | 1 | 1: `cts`/`cd` gate the link; 0: both ignored for gating |
| cfg_sync_char | input | BYTE_W (8) | Sync character for transmit fill and receive discard |
| cfg_sync_pat | input | PAT_W (16) | Receive alignment pattern, bit 15 earliest |
| cfg_max_len | input | LEN_W (8) | Bytes per received frame, 0 = unlimited |
| cts | input | 1 | Clear-to-send |
| cd | input | 1 | Carrier detect / external sync |
| tx_data | input | BYTE_W (8) | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding register empty |
| tx_line | output | 1 | Serial transmit line |
| tx_underrun | output | 1 | Data stream broke in a no-sync mode (pulse) |
| rx_line | input | 1 | Serial receive line |
| rx_data | output | BYTE_W (8) | Received byte |
| rx_valid | output | 1 | `rx_data` holds an unaccepted byte |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| rx_synced | output | 1 | Receiver is byte-aligned |
| rx_frame_done | output | 1 | Last byte of a frame delivered (pulse) |
| rx_overrun | output | 1 | A byte was dropped (pulse) |

## Verification
The bench runs all four sync modes, mostly in loopback, and drives the receive line bit by bit for the external-sync, drop and overrun cases.

It sends the sync character as data in both transmit settings:
- if the receiver failed to discard it, the frame would close one byte early;
- if it discarded it in a raw mode, the byte would be missing from the frame.

It drops `cd` in the middle of a frame and then receives a full new frame. A design that kept the old byte count would raise `rx_frame_done` one byte too soon.

It holds `cts` low with a byte pending. A transmitter that ignored the gate would emit sync bits or free the holding register.

It also stops the clock in the middle of a frame, and fills the receive register while `rx_ready` is low. A design that overwrote the pending byte would show the later value on `rx_data`.

// File: rtl/sx_pkg.sv
// Shared types for the synchronous serial transceiver.
package sx_pkg;

    // Source chosen for the next transmit slot.
    typedef enum logic [1:0] {
        SRC_HOLD,   // gated by cts: line kept at ones, nothing consumed
        SRC_DATA,   // held byte moves into the shifter
        SRC_SYNC,   // sync character fills the empty slot
        SRC_IDLE    // ones fill the empty slot (no-sync modes)
    } tx_src_e;

endpackage

// File: rtl/sx_tx.sv
// Transmit path: one-byte holding register plus an MSB-first shifter.
// Every BYTE_W tx_clk cycles a new slot begins and picks its content.
// Assumes: configuration inputs static while running; start_ok is the
// already-combined hardware/software view of cts.
module sx_tx
    import sx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              no_sync,
    input  logic              start_ok,
    input  logic [BYTE_W-1:0] sync_char,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line,
    output logic              underrun
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hold;
    logic              hold_full;
    logic [CW-1:0]     bit_idx;
    logic              prev_data;
    logic              ur_q;
    logic              slot_end;
    tx_src_e           src;

    // Decide what the next slot carries.
    always_comb begin
        slot_end = (bit_idx == LAST);
        if (!start_ok)        src = SRC_HOLD;
        else if (hold_full)   src = SRC_DATA;
        else if (!no_sync)    src = SRC_SYNC;
        else                  src = SRC_IDLE;
    end

    // Holding register, shifter, slot counter and underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            hold      <= '0;
            hold_full <= 1'b0;
            bit_idx   <= LAST;
            prev_data <= 1'b0;
            ur_q      <= 1'b0;
        end else begin
            ur_q <= 1'b0;
            if (in_valid && !hold_full) begin
                hold      <= in_data;
                hold_full <= 1'b1;
            end
            if (slot_end) begin
                bit_idx <= '0;
                unique case (src)
                    SRC_DATA: begin
                        shreg     <= hold;
                        hold_full <= 1'b0;
                        prev_data <= 1'b1;
                    end
                    SRC_SYNC: begin
                        shreg     <= sync_char;
                        prev_data <= 1'b0;
                    end
                    SRC_IDLE: begin
                        shreg     <= '1;
                        ur_q      <= prev_data;
                        prev_data <= 1'b0;
                    end
                    default: begin
                        shreg     <= '1;
                        prev_data <= 1'b0;
                    end
                endcase
            end else begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {shreg[BYTE_W-2:0], 1'b1};
            end
        end
    end

    assign in_ready = !hold_full;
    assign line     = shreg[BYTE_W-1];
    assign underrun = ur_q;

endmodule

// File: rtl/sx_rx_sync.sv
// Receive alignment: keeps the last PAT_W line bits and tracks whether
// the receiver is byte-aligned. Alignment comes from a pattern match or
// from the external cd input, and is lost on frame end or on gate loss.
// Assumes: gate_ok already folds in the hardware/software control choice.
module sx_rx_sync #(
    parameter int PAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             ext_sync,
    input  logic             cd,
    input  logic             gate_ok,
    input  logic [PAT_W-1:0] pattern,
    input  logic             drop,
    output logic             synced
);
    logic [PAT_W-1:0] window;
    logic [PAT_W-1:0] window_nx;
    logic             acquire;
    logic             synced_q;

    // Window including the bit sampled at this edge, and the acquire rule.
    always_comb begin
        window_nx = {window[PAT_W-2:0], line};
        acquire   = ext_sync ? cd : (gate_ok && (window_nx == pattern));
    end

    // Bit history for the pattern hunt.
    always_ff @(posedge clk) begin
        if (!rst_n) window <= '1;
        else        window <= window_nx;
    end

    // Aligned flag: set on acquire, cleared on frame end or gate loss.
    always_ff @(posedge clk) begin
        if (!rst_n)          synced_q <= 1'b0;
        else if (synced_q)   synced_q <= !(drop || !gate_ok);
        else                 synced_q <= acquire;
    end

    assign synced = synced_q;

endmodule

// File: rtl/sx_rx_byte.sv
// Receive byte assembly: shifts aligned bits MSB first, drops sync fill,
// delivers bytes on a valid/ready handshake, counts bytes per frame and
// flags overrun. Assumes synced comes from sx_rx_sync in the same domain.
module sx_rx_byte #(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              synced,
    input  logic              gate_ok,
    input  logic              discard_en,
    input  logic [BYTE_W-1:0] sync_char,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              frame_done,
    output logic              overrun,
    output logic              frame_end
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nx;
    logic [CW-1:0]     bit_idx;
    logic [LEN_W-1:0]  fcount;
    logic [LEN_W:0]    fcount_nx;
    logic              take;
    logic              byte_done;
    logic              deliver;
    logic              valid_q;
    logic              done_q;
    logic              ovr_q;
    logic [BYTE_W-1:0] data_q;

    // Byte completion, sync discard and frame-end detection.
    always_comb begin
        take      = synced && gate_ok;
        shreg_nx  = {shreg[BYTE_W-2:0], line};
        byte_done = take && (bit_idx == LAST);
        deliver   = byte_done && !(discard_en && (shreg_nx == sync_char));
        fcount_nx = {1'b0, fcount} + (LEN_W+1)'(1);
        frame_end = deliver && (max_len != '0) && (fcount_nx == {1'b0, max_len});
    end

    // Shifter, counters, output register and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            fcount  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            if (valid_q && out_ready) valid_q <= 1'b0;
            if (!take) begin
                bit_idx <= '0;
                fcount  <= '0;
            end else begin
                shreg   <= shreg_nx;
                bit_idx <= byte_done ? '0 : bit_idx + 1'b1;
                if (deliver) begin
                    if (valid_q && !out_ready) begin
                        ovr_q <= 1'b1;
                    end else begin
                        data_q  <= shreg_nx;
                        valid_q <= 1'b1;
                    end
                    fcount <= frame_end ? '0 : fcount_nx[LEN_W-1:0];
                    done_q <= frame_end;
                end
            end
        end
    end

    assign out_data   = data_q;
    assign out_valid  = valid_q;
    assign frame_done = done_q;
    assign overrun    = ovr_q;

endmodule

// File: rtl/sx_transceiver.sv
// Top of the synchronous serial transceiver. Combines the control-mode
// gating of cts/cd and wires the transmit path and the two receive
// stages. Assumes rst_n is synchronous and spans an edge of both clocks.
module sx_transceiver #(
    parameter int BYTE_W = 8,
    parameter int PAT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              tx_clk,
    input  logic              rx_clk,
    input  logic              rst_n,
    input  logic              cfg_no_tx_sync,
    input  logic              cfg_ext_sync,
    input  logic              cfg_hw_ctl,
    input  logic [BYTE_W-1:0] cfg_sync_char,
    input  logic [PAT_W-1:0]  cfg_sync_pat,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              cts,
    input  logic              cd,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    output logic              tx_underrun,
    input  logic              rx_line,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_synced,
    output logic              rx_frame_done,
    output logic              rx_overrun
);
    logic cts_ok;
    logic cd_ok;
    logic frame_end;

    // Hardware control lets the pins gate; software control ignores them.
    always_comb begin
        cts_ok = !cfg_hw_ctl || cts;
        cd_ok  = !cfg_hw_ctl || cd;
    end

    sx_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (tx_clk),
        .rst_n     (rst_n),
        .no_sync   (cfg_no_tx_sync),
        .start_ok  (cts_ok),
        .sync_char (cfg_sync_char),
        .in_data   (tx_data),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .line      (tx_line),
        .underrun  (tx_underrun)
    );

    sx_rx_sync #(.PAT_W(PAT_W)) u_sync (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .line     (rx_line),
        .ext_sync (cfg_ext_sync),
        .cd       (cd),
        .gate_ok  (cd_ok),
        .pattern  (cfg_sync_pat),
        .drop     (frame_end),
        .synced   (rx_synced)
    );

    sx_rx_byte #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_byte (
        .clk        (rx_clk),
        .rst_n      (rst_n),
        .line       (rx_line),
        .synced     (rx_synced),
        .gate_ok    (cd_ok),
        .discard_en (!cfg_no_tx_sync),
        .sync_char  (cfg_sync_char),
        .max_len    (cfg_max_len),
        .out_ready  (rx_ready),
        .out_data   (rx_data),
        .out_valid  (rx_valid),
        .frame_done (rx_frame_done),
        .overrun    (rx_overrun),
        .frame_end  (frame_end)
    );

endmodule

// File: rtl/sx_chk.sv
// Protocol checks for sx_transceiver, attached with bind below.
module sx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              tx_clk,
    input logic              rx_clk,
    input logic              rst_n,
    input logic              cfg_no_tx_sync,
    input logic              cfg_ext_sync,
    input logic              cfg_hw_ctl,
    input logic              cd,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_line,
    input logic              tx_underrun,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_synced,
    input logic              rx_frame_done,
    input logic              rx_overrun
);
    // R1
    tx_reset_idle_chk: assert property (@(posedge tx_clk)
        !rst_n |=> (tx_ready && tx_line && !tx_underrun));

    // R1
    rx_reset_idle_chk: assert property (@(posedge rx_clk)
        !rst_n |=> (!rx_valid && !rx_synced && !rx_frame_done && !rx_overrun));

    // R2
    hold_busy_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R3
    underrun_ones_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        tx_underrun |-> (tx_line && cfg_no_tx_sync));

    // R5
    ext_acquire_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (cfg_ext_sync && $rose(rx_synced)) |-> $past(cd));

    // R7
    frame_rehunt_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_frame_done |-> !rx_synced);

    // R7
    frame_last_valid_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (rx_frame_done && !rx_overrun) |-> rx_valid);

    // R9
    cd_loss_drop_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (rx_synced && cfg_hw_ctl && !cd) |=> !rx_synced);

    // R11
    overrun_keep_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_overrun |-> (rx_valid && $stable(rx_data)));

endmodule

bind sx_transceiver sx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .tx_clk         (tx_clk),
    .rx_clk         (rx_clk),
    .rst_n          (rst_n),
    .cfg_no_tx_sync (cfg_no_tx_sync),
    .cfg_ext_sync   (cfg_ext_sync),
    .cfg_hw_ctl     (cfg_hw_ctl),
    .cd             (cd),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_line        (tx_line),
    .tx_underrun    (tx_underrun),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .rx_synced      (rx_synced),
    .rx_frame_done  (rx_frame_done),
    .rx_overrun     (rx_overrun)
);

// File: tb/sim_sx_transceiver.sv
module sim_sx_transceiver;
    logic       clk = 1'b0;
    logic       run = 1'b1;
    logic       rst_n = 1'b0;
    logic       no_tx_sync = 1'b0, ext_sync = 1'b0, hw_ctl = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic [15:0] sync_pat = 16'h1616;
    logic [7:0] max_len = 8'd0;
    logic       cts = 1'b1, cd = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, tx_line, tx_underrun;
    logic       loopback = 1'b1;
    logic       rx_drv = 1'b1;
    logic       rx_line;
    logic [7:0] rx_data;
    logic       rx_valid, rx_synced, rx_frame_done, rx_overrun;
    logic       rx_ready = 1'b1;

    int tests = 0, fails = 0, cyc = 0;
    int ovr_cnt = 0, ur_cnt = 0;
    logic [7:0] got[$];
    int frame_at[$];

    assign rx_line = loopback ? tx_line : rx_drv;

    sx_transceiver u0 (
        .tx_clk(clk), .rx_clk(clk), .rst_n(rst_n),
        .cfg_no_tx_sync(no_tx_sync), .cfg_ext_sync(ext_sync), .cfg_hw_ctl(hw_ctl),
        .cfg_sync_char(sync_char), .cfg_sync_pat(sync_pat), .cfg_max_len(max_len),
        .cts(cts), .cd(cd),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_line(tx_line), .tx_underrun(tx_underrun),
        .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_synced(rx_synced), .rx_frame_done(rx_frame_done), .rx_overrun(rx_overrun)
    );

    // 250 MHz clock that can be held still.
    initial forever begin
        #2;
        if (run) clk = ~clk;
    end

    // Collect delivered bytes, frame ends and event pulses between edges.
    always @(negedge clk) begin
        if (rx_valid && rx_ready) got.push_back(rx_data);
        if (rx_frame_done) frame_at.push_back(got.size());
        if (rx_overrun) ovr_cnt++;
        if (tx_underrun) ur_cnt++;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        got.delete(); frame_at.delete();
        ovr_cnt = 0; ur_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic c);
        @(negedge clk);
        rx_drv = b; cd = c;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i], cd);
    endtask

    // Returns 16 consecutive tx_line samples, earliest in bit 15.
    task automatic grab16(output logic [15:0] h);
        h = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            h = {h[14:0], tx_line};
        end
    endtask

    function automatic bit is_rot(input logic [15:0] h, input logic [15:0] p);
        for (int k = 0; k < 8; k++)
            if (h == ((p << k) | (p >> (16 - k)))) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] dval(input int i);
        return 8'((i * 53 + 7) & 255);
    endfunction

    initial begin
        logic [15:0] h;
        // ---------- R1: reset state ----------
        repeat (3) @(negedge clk);
        #1;
        chk("R1 tx_line", tx_line, 1);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 rx_valid/synced/pulses",
            {rx_valid, rx_synced, rx_frame_done, rx_overrun, tx_underrun}, 0);

        // ---------- Mode: sync inserted, pattern hunt, loopback ----------
        no_tx_sync = 0; ext_sync = 0; hw_ctl = 0; max_len = 8'd6; loopback = 1;
        do_reset();
        settle(40);
        chk("R4 acquired on sync fill", rx_synced, 1);
        chk("R6 idle syncs discarded", got.size(), 0);
        grab16(h);
        chk("R3 idle slots carry sync char", is_rot(h, 16'h1616), 1);
        for (int i = 0; i < 7; i++) put_byte(i == 2 ? 8'h16 : dval(i));
        settle(60);
        chk("R6 sync byte as data dropped (count)", got.size(), 6);
        for (int i = 0; i < 6; i++)
            chk("R2 loopback byte order", got[i], dval(i < 2 ? i : i + 1));
        chk("R7 frame end after max_len", frame_at.size() > 0 ? frame_at[0] : -1, 6);
        chk("R3 no underrun in sync mode", ur_cnt, 0);
        chk("R7 re-hunt re-acquires", rx_synced, 1);
        // R12: stop the clock in the middle of the second frame
        fork
            for (int i = 0; i < 6; i++) put_byte(dval(i + 10));
            begin
                repeat (20) @(negedge clk);
                run = 1'b0; #400; run = 1'b1;
            end
        join
        settle(60);
        chk("R12 frame intact after clock stop", got.size(), 12);
        for (int i = 0; i < 6; i++)
            chk("R12 byte after clock stop", got.size() > 6 + i ? got[6 + i] : -1, dval(i + 10));
        chk("R12 second frame end", frame_at.size() > 1 ? frame_at[1] : -1, 12);

        // ---------- Mode: raw transmit, pattern hunt, loopback ----------
        no_tx_sync = 1; ext_sync = 0; max_len = 8'd4;
        do_reset();
        settle(20);
        grab16(h);
        chk("R3 raw idle line is ones", h, 16'hffff);
        chk("R4 no alignment without pattern", rx_synced, 0);
        put_byte(8'h16); put_byte(8'h16);
        put_byte(8'hA1); put_byte(8'h16); put_byte(8'h5B); put_byte(8'hC4);
        settle(60);
        chk("R4 bytes after match", got.size(), 4);
        chk("R4 first byte", got.size() > 0 ? got[0] : -1, 8'hA1);
        chk("R6 sync value delivered in raw mode", got.size() > 1 ? got[1] : -1, 8'h16);
        chk("R4 last byte", got.size() > 3 ? got[3] : -1, 8'hC4);
        chk("R7 raw frame end", frame_at.size() > 0 ? frame_at[0] : -1, 4);
        chk("R3 single underrun after stream", ur_cnt, 1);
        chk("R3 line ones after underrun", tx_line, 1);

        // ---------- R8: cts gating in hardware mode ----------
        no_tx_sync = 0; hw_ctl = 1; cts = 0; cd = 1; max_len = 8'd0;
        do_reset();
        settle(20);
        grab16(h);
        chk("R8 gated slots send ones", h, 16'hffff);
        put_byte(8'h5C);
        settle(20);
        chk("R8 held byte not consumed", tx_ready, 0);
        grab16(h);
        chk("R8 still ones with byte pending", h, 16'hffff);
        cts = 1;
        settle(12);
        chk("R8 byte released once cts high", tx_ready, 1);

        // ---------- R10: software mode ignores cts and cd ----------
        hw_ctl = 0; cts = 0; cd = 0;
        do_reset();
        settle(40);
        chk("R10 cts ignored, syncs flow", rx_synced, 1);
        grab16(h);
        chk("R10 line carries sync char", is_rot(h, 16'h1616), 1);

        // ---------- External sync, direct drive ----------
        loopback = 0; no_tx_sync = 0; ext_sync = 1; hw_ctl = 1; max_len = 8'd2;
        cd = 0; rx_drv = 1;
        do_reset();
        send_byte(8'h16); send_byte(8'h16); send_byte(8'h00);
        settle(1);
        chk("R5 pattern ignored in ext mode", rx_synced, 0);
        send_bit(1, 1);
        send_byte(8'h16); send_byte(8'hA5); send_byte(8'h16); send_byte(8'h3C);
        send_bit(1, 0);
        settle(3);
        chk("R5 ext frame size", got.size(), 2);
        chk("R5 ext first byte", got.size() > 0 ? got[0] : -1, 8'hA5);
        chk("R6 ext second byte", got.size() > 1 ? got[1] : -1, 8'h3C);
        chk("R7 ext frame end", frame_at.size() > 0 ? frame_at[0] : -1, 2);
        // R9: cd loss in the middle of a frame
        send_bit(1, 1);
        send_byte(8'h11);
        send_bit(0, 1); send_bit(0, 1); send_bit(1, 1); send_bit(0, 1);
        send_bit(1, 0); send_bit(1, 0);
        settle(1);
        chk("R9 cd loss drops alignment", rx_synced, 0);
        send_bit(1, 1);
        send_byte(8'h33); send_byte(8'h44);
        send_bit(1, 0);
        settle(3);
        chk("R9 bytes after re-acquire", got.size(), 5);
        chk("R9 byte count restarted", frame_at.size() > 1 ? frame_at[1] : -1, 5);
        chk("R9 last byte", got.size() > 4 ? got[4] : -1, 8'h44);

        // ---------- R11 overrun, R7 unlimited frame ----------
        no_tx_sync = 1; ext_sync = 0; hw_ctl = 1; max_len = 8'd0;
        cd = 1; rx_ready = 0; rx_drv = 1;
        do_reset();
        send_byte(8'h16); send_byte(8'h16);
        send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h77);
        send_bit(1, 0);
        settle(3);
        chk("R11 two bytes dropped", ovr_cnt, 2);
        chk("R11 pending byte kept", rx_data, 8'h5A);
        chk("R11 valid kept", rx_valid, 1);
        chk("R7 unlimited frame never ends", frame_at.size(), 0);
        chk("R9 cd loss in pattern mode", rx_synced, 0);
        @(posedge clk); #1 rx_ready = 1;
        settle(3);
        chk("R11 pending byte delivered once", got.size(), 1);
        chk("R11 delivered value", got.size() > 0 ? got[0] : -1, 8'h5A);

        summary();
        $finish;
    end
endmodule